// File: doc/BRIEF.md
# Summation-combiner keystream generator

This block produces a one-bit-per-cycle keystream for a packet stream cipher and uses it to scramble a serial data bit. Four linear feedback shift registers (lanes of 25, 31, 33 and 39 stages, 128 in all) drive a combiner that adds their output bits and keeps two bits of carry memory. The keystream bit is the XOR of the four lane outputs and one carry bit. XOR-ing a data bit with it both encrypts and decrypts.

A run starts when `init` is raised. While `init` is high the lanes and the combiner are cleared. The 128-bit key, 48-bit device address and 26-bit clock value are also captured in parallel into four input shift registers. When `init` falls, the input registers feed the lanes one bit per cycle. Each lane's feedback stays switched off until that lane has received as many bits as it has stages. The last 128 keystream bits produced during this warm-up are collected. At step 240 they are loaded back into the lanes in parallel. From step 241 onward the keystream is live. `en` stands in for a gated clock: when it is low, all state holds.

Top module: `sumcomb_keystream`

## Requirements
- R1: After reset, `ks_valid`, `ks_bit` and `ct_bit` are 0. They stay 0 until an `init` has been seen and warm-up has completed, whatever `en` does.
- R2: During a cycle with `init` high, the next edge does the following. All lane stages become 0. The combiner memory (current and previous carry) becomes 0. The step counter becomes 0. The input registers load from the 208-bit vector V = {key_in, addr_in, clk26_in, 6'b011011}: lane 0 takes V[207:159], lane 1 V[158:104], lane 2 V[103:55] and lane 3 V[54:0]. `ks_valid` is 0 in any cycle where `init` is high.
- R3: On each running step, lane i takes the top bit of its input register. The register shifts up by one, and the level of the load control (0 while running) enters its bottom position. So after its data bits, a lane receives only zeros.
- R4: Each lane shifts toward its top bit, and the new bit 0 is in XOR (gate AND fb). fb is the XOR of the stage bits selected by these masks: lane 0 0x1080880, lane 1 0x40808800, lane 2 0x108800008, lane 3 0x4808000008. The gate is open once the step counter is at least the lane length (25, 31, 33, 39).
- R5: Each running step forms y, the count of the four lane top bits, and s = (y + c) >> 1. The new carry is s XOR c XOR T(p), where p is the previous carry and T({a,b}) = {b, a^b}. The keystream bit z is the XOR of the four top bits and c[0], all taken before the step.
- R6: During steps 0 to 239, each z is shifted into a 128-bit collection register, with the newest bit at bit 0. On step 240 the lanes load instead of shifting: lane 0 from bits [24:0], lane 1 from [55:25], lane 2 from [88:56] and lane 3 from [127:89]. The combiner holds on that step, and the counter then stays at 241.
- R7: While the counter is 241 and `init` is low, `ks_valid` is 1, `ks_bit` equals z and `ct_bit` equals `pt_bit` XOR z. Otherwise `ks_bit` and `ct_bit` are 0.
- R8: A cycle with `en` low and `init` low changes no state. The following outputs continue the same sequence as if the cycle had not occurred.
- R9: Raising `init` at any point, including during live keystream, abandons the run and restarts warm-up from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Clear lanes and capture key, address and clock value |
| en | input | 1 | Step enable (gated-clock equivalent) |
| key_in | input | 128 | Session key |
| addr_in | input | 48 | Device address |
| clk26_in | input | 26 | Clock value |
| pt_bit | input | 1 | Serial data bit to scramble |
| ct_bit | output | 1 | Scrambled data bit |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | Keystream live |

## Verification
The bench steps a bit-accurate reference through warm-up and live operation under random keys, random `en` gaps and random data bits, and compares every cycle. It targets several specific failures:
- A switch that closes one step early or late, or a wrong tap, changes the whole keystream from that lane's fill point onward.
- A reload off by one step, or loading from misordered slices, garbles every live bit.
- A combiner that advances on the reload step shifts the carry sequence.
- Any state moving during `en`-low cycles makes the sequence diverge.
- A re-init during live output that fails to drop `ks_valid` at once, or that keeps stale carry memory, is caught on the next cycles.

// File: rtl/skg_pkg.sv
package skg_pkg;
  localparam int NLANE      = 4;
  localparam int KEY_W      = 128;
  localparam int ADDR_W     = 48;
  localparam int CLKV_W     = 26;
  localparam int FILL_W     = 6;
  localparam logic [FILL_W-1:0] FILL = 6'b011011;
  localparam int SEED_W     = KEY_W + ADDR_W + CLKV_W + FILL_W;
  localparam int COL_W      = 128;
  localparam int CNT_W      = 8;
  localparam int RELOAD_AT  = 240;
  localparam int LIVE_AT    = RELOAD_AT + 1;
  localparam int LANE_LEN [NLANE] = '{25, 31, 33, 39};
  localparam int FEED_W   [NLANE] = '{49, 55, 49, 55};
  localparam int FEED_LO  [NLANE] = '{159, 104, 55, 0};
  localparam int RELD_LO  [NLANE] = '{0, 25, 56, 89};
  localparam logic [63:0] LANE_TAPS [NLANE] = '{
    64'h0000_0000_0108_0880,
    64'h0000_0000_4080_8800,
    64'h0000_0001_0880_0008,
    64'h0000_0048_0800_0008
  };
endpackage

// File: rtl/feed_sreg.sv
module feed_sreg #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic         bit_out
);
  logic [W-1:0] q, q_d;

  always_comb begin
    q_d = q;
    if (load)     q_d = din;
    else if (adv) q_d = {q[W-2:0], load};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign bit_out = q[W-1];

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (q[0] == 1'b0));
endmodule

// File: rtl/gated_lfsr.sv
module gated_lfsr #(
  parameter int          LEN  = 25,
  parameter logic [63:0] TAPS = 64'h0108_0880
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic           gate,
  input  logic           ld,
  input  logic [LEN-1:0] ld_val,
  input  logic           in_bit,
  output logic           top_bit
);
  logic [LEN-1:0] s, s_d;
  logic           fb;

  assign fb = ^(s & TAPS[LEN-1:0]);

  always_comb begin
    s_d = s;
    if (clr)      s_d = '0;
    else if (ld)  s_d = ld_val;
    else if (adv) s_d = {s[LEN-2:0], in_bit ^ (gate & fb)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s <= '0;
    else        s <= s_d;
  end

  assign top_bit = s[LEN-1];

  // R2
  lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s == '0));
  // R8
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv && !ld) |=> $stable(s));
  // R4
  open_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !ld && !gate) |=> (s[0] == $past(in_bit)));
endmodule

// File: rtl/sum_combiner.sv
module sum_combiner #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [N-1:0] x,
  output logic         z
);
  logic [1:0] c, cp, c_d, cp_d;
  logic [2:0] y;
  logic [3:0] tot;
  logic [1:0] s;

  always_comb begin
    y = '0;
    for (int i = 0; i < N; i++) y = y + 3'(x[i]);
    tot = 4'(y) + 4'(c);
    s   = tot[2:1];
    z   = (^x) ^ c[0];
    c_d  = c;
    cp_d = cp;
    if (clr) begin
      c_d  = '0;
      cp_d = '0;
    end else if (adv) begin
      c_d  = s ^ c ^ {cp[0], cp[1] ^ cp[0]};
      cp_d = c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c  <= '0;
      cp <= '0;
    end else begin
      c  <= c_d;
      cp <= cp_d;
    end
  end

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable({c, cp}));
  // R5
  carry_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (cp == $past(c)));
endmodule

// File: rtl/ks_ctl.sv
module ks_ctl
  import skg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  output logic             adv,
  output logic             reload,
  output logic             collect_en,
  output logic             live,
  output logic [NLANE-1:0] gate
);
  logic             run, run_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             go;

  assign go = run & en & ~init;

  always_comb begin
    run_d = run;
    cnt_d = cnt;
    if (init) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (go && (cnt < CNT_W'(LIVE_AT))) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= run_d;
      cnt <= cnt_d;
    end
  end

  assign adv        = go & (cnt != CNT_W'(RELOAD_AT));
  assign reload     = go & (cnt == CNT_W'(RELOAD_AT));
  assign collect_en = adv & (cnt < CNT_W'(RELOAD_AT));
  assign live       = run & (cnt == CNT_W'(LIVE_AT));

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_gate
    assign gate[gi] = (cnt >= CNT_W'(LANE_LEN[gi]));
  end

  // R6
  reload_then_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> live);
  // R6
  live_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> $past(reload));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (run && cnt == '0));
endmodule

// File: rtl/sumcomb_keystream.sv
module sumcomb_keystream
  import skg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          en,
  input  logic [127:0]  key_in,
  input  logic [47:0]   addr_in,
  input  logic [25:0]   clk26_in,
  input  logic          pt_bit,
  output logic          ct_bit,
  output logic          ks_bit,
  output logic          ks_valid
);
  logic [SEED_W-1:0] seed_vec;
  logic [COL_W-1:0]  col, col_d;
  logic [NLANE-1:0]  lane_in, lane_top, gate;
  logic              adv, reload, collect_en, live, z;

  assign seed_vec = {key_in, addr_in, clk26_in, FILL};

  ks_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .init(init), .en(en),
    .adv(adv), .reload(reload), .collect_en(collect_en),
    .live(live), .gate(gate)
  );

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    feed_sreg #(.W(FEED_W[gi])) u_feed (
      .clk(clk), .rst_n(rst_n), .load(init), .adv(adv),
      .din(seed_vec[FEED_LO[gi] +: FEED_W[gi]]),
      .bit_out(lane_in[gi])
    );
    gated_lfsr #(.LEN(LANE_LEN[gi]), .TAPS(LANE_TAPS[gi])) u_lfsr (
      .clk(clk), .rst_n(rst_n), .clr(init), .adv(adv),
      .gate(gate[gi]), .ld(reload),
      .ld_val(col[RELD_LO[gi] +: LANE_LEN[gi]]),
      .in_bit(lane_in[gi]), .top_bit(lane_top[gi])
    );
  end

  sum_combiner #(.N(NLANE)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(init), .adv(adv),
    .x(lane_top), .z(z)
  );

  always_comb begin
    col_d = col;
    if (collect_en) col_d = {col[COL_W-2:0], z};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col <= '0;
    else        col <= col_d;
  end

  assign ks_valid = live & ~init;
  assign ks_bit   = ks_valid & z;
  assign ct_bit   = ks_valid & (pt_bit ^ z);

  // R7
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ks_valid |-> (!ks_bit && !ct_bit));
  // R2
  init_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !ks_valid);
endmodule

// File: tb/tb_sumcomb_keystream.sv
module tb_sumcomb_keystream;
  logic         clk = 1'b0;
  logic         rst_n, init, en, pt_bit;
  logic [127:0] key_in;
  logic [47:0]  addr_in;
  logic [25:0]  clk26_in;
  logic         ct_bit, ks_bit, ks_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sumcomb_keystream dut (
    .clk(clk), .rst_n(rst_n), .init(init), .en(en),
    .key_in(key_in), .addr_in(addr_in), .clk26_in(clk26_in),
    .pt_bit(pt_bit), .ct_bit(ct_bit), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  // reference model, built from the requirements
  int LL [4] = '{25, 31, 33, 39};
  int SW [4] = '{49, 55, 49, 55};
  int SL [4] = '{159, 104, 55, 0};
  int RL [4] = '{0, 25, 56, 89};
  logic [38:0] TM [4] = '{39'h1080880, 39'h40808800, 39'h108800008, 39'h4808000008};

  logic [38:0]  ml [4];
  logic [54:0]  ms [4];
  logic [1:0]   mc, mcp;
  logic [127:0] mcol;
  int           mcnt;
  bit           mrun;

  function automatic logic model_z();
    logic r;
    r = mc[0];
    for (int i = 0; i < 4; i++) r = r ^ ml[i][LL[i]-1];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ml[i] = '0; ms[i] = '0; end
      mc = '0; mcp = '0; mcol = '0; mcnt = 0; mrun = 1'b0;
    end else if (init) begin
      logic [207:0] v;
      v = {key_in, addr_in, clk26_in, 6'b011011};
      for (int i = 0; i < 4; i++) begin
        ml[i] = '0;
        ms[i] = 55'(v >> SL[i]) & ((55'd1 << SW[i]) - 55'd1);
      end
      mc = '0; mcp = '0; mcnt = 0; mrun = 1'b1;
    end else if (en && mrun) begin
      if (mcnt == 240) begin
        for (int i = 0; i < 4; i++)
          ml[i] = 39'(mcol >> RL[i]) & ((39'd1 << LL[i]) - 39'd1);
        mcnt = 241;
      end else begin
        int y, s;
        logic zz, nb, fb;
        logic [1:0] cn;
        zz = model_z();
        y = 0;
        for (int i = 0; i < 4; i++) y += int'(ml[i][LL[i]-1]);
        s = (y + int'(mc)) / 2;
        cn = 2'(s) ^ mc ^ {mcp[0], mcp[1] ^ mcp[0]};
        for (int i = 0; i < 4; i++) begin
          fb = ^(ml[i] & TM[i]);
          nb = ms[i][SW[i]-1] ^ ((mcnt >= LL[i]) ? fb : 1'b0);
          ms[i] = (ms[i] << 1) & ((55'd1 << SW[i]) - 55'd1);
          ml[i] = {ml[i][37:0], nb} & ((39'd1 << LL[i]) - 39'd1);
        end
        if (mcnt < 240) mcol = {mcol[126:0], zz};
        mcp = mc;
        mc  = cn;
        if (mcnt < 241) mcnt++;
      end
    end
  end

  task automatic check_out(input string tag);
    logic ev, ek, ec;
    ev = rst_n && mrun && (mcnt == 241) && !init;
    ek = ev & model_z();
    ec = ev & (pt_bit ^ model_z());
    checks += 3;
    if (ks_valid !== ev) begin
      fails++;
      $display("FAIL %s ks_valid got %0b exp %0b (step %0d)", tag, ks_valid, ev, mcnt);
    end
    if (ks_bit !== ek) begin
      fails++;
      $display("FAIL %s ks_bit got %0b exp %0b (step %0d)", tag, ks_bit, ek, mcnt);
    end
    if (ct_bit !== ec) begin
      fails++;
      $display("FAIL %s ct_bit got %0b exp %0b (step %0d)", tag, ct_bit, ec, mcnt);
    end
  endtask

  task automatic step(input logic i_init, input logic i_en, input string tag);
    @(negedge clk);
    init   = i_init;
    en     = i_en;
    pt_bit = 1'($urandom());
    #1;
    check_out(tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one full run; en_pct sets the share of enabled cycles
  task automatic run_session(input int en_pct, input int live_cycles);
    step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, "R2");
    while (mcnt < 241) begin
      logic e;
      e = ($urandom_range(99) < en_pct);
      step(1'b0, e, e ? "R3 R4 R5 R6" : "R8");
    end
    for (int k = 0; k < live_cycles; k++) begin
      logic e;
      e = ($urandom_range(99) < en_pct);
      step(1'b0, e, e ? "R5 R7" : "R8");
    end
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; init = 1'b0; en = 1'b0; pt_bit = 1'b0;
    key_in = '0; addr_in = '0; clk26_in = '0;
    repeat (2) @(negedge clk);
    #1 check_out("R1");
    @(negedge clk) rst_n = 1'b1;
    // R1: enabled but never initialised
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, "R1");

    // random key, always enabled
    key_in   = {$urandom(), $urandom(), $urandom(), $urandom()};
    addr_in  = {16'($urandom()), $urandom()};
    clk26_in = 26'($urandom());
    run_session(100, 300);

    // all-zero inputs: only the fill constant seeds the lanes
    key_in = '0; addr_in = '0; clk26_in = '0;
    run_session(100, 150);

    // all ones, sparse enable (R8)
    key_in = '1; addr_in = '1; clk26_in = '1;
    run_session(60, 200);

    // random key, then restart mid-stream (R9)
    key_in   = {$urandom(), $urandom(), $urandom(), $urandom()};
    addr_in  = {16'($urandom()), $urandom()};
    clk26_in = 26'($urandom());
    run_session(85, 40);
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, "R9");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, "R9");
    clk26_in = clk26_in + 26'd1;
    run_session(90, 250);

    report();
  end
endmodule